// File: doc/BRIEF.md
# Latched Diagnostic Status Bank

This block gathers fault and diagnostic event inputs from a multi-channel power stage and holds them as sticky status bits. The bits are arranged as five bytes: one global byte and one byte for each of four channels. A host reads the bytes as a burst through a byte-level read port. The host opens a transaction with a start pulse that carries a direction bit. It then pulls bytes one per request strobe and closes the transaction with a stop pulse.

When a read transaction starts, the block copies all five bytes into a snapshot, so the bytes of one burst agree with each other while new events keep accumulating. Reported bits are cleared only after the fifth byte has been handed out. The two-bit load-detection field of each channel byte does not take part in the clear. The output-offset bit is forced to one instead of being cleared. A mode input selects how the load field is presented: an AC-load flag or a two-bit DC load code.

Top module: `diag_status_bank`

## Requirements
- R1: After reset `rd_valid` and `rd_data` are 0, and the first complete burst returns 0x00 in all five bytes.
- R2: An event input held high for one cycle sets its status bit. The bit stays set through any number of partial bursts and through bursts that did not report it. Channel byte layout: bit 7 temperature pre-warning, bit 6 speaker fault, bits 5:4 load field, bit 3 shorted load, bit 2 output offset, bit 1 short to supply, bit 0 short to ground. Per-channel event group `ch_flt_evt[6c+5:6c]` maps its bits 5,4,3,2,1,0 to byte bits 7,6,3,2,1,0. Global event bit i maps to global byte bit i.
- R3: A `rd_req` in an open read transaction drives `rd_valid` high with the data byte on the cycle after the request edge. Byte 0 is the global byte and byte k is channel k-1.
- R4: The bytes of a burst are the status as it stood at the start pulse. Events arriving after that edge do not appear in the same burst.
- R5: The clear happens only when the fifth byte is read. It removes the reported bits of the global byte and bits 7, 6, 3, 1 and 0 of each channel byte. A transaction stopped before the fifth byte clears nothing.
- R6: Bits 5:4 of each channel byte keep their value across a completed burst. They change only when that channel's `ch_load_vld` is high, which loads `ch_load_res[2c+1:2c]`.
- R7: After a completed burst, bit 2 of every channel byte reads 1.
- R8: With `ac_mode`=0, bits 5:4 show the stored code (00 normal, 01 line driver, 10 open, 11 invalid). With `ac_mode`=1, bit 5 reads 0 and bit 4 shows bit 0 of the stored code (1 means AC load present). The mode is taken at the start pulse.
- R9: An event in the same cycle as the clear keeps its bit set. So does an event that arrived after the snapshot and was not reported.
- R10: Requests after the fifth byte return 0x00 with `rd_valid` high and cause no further clear.
- R11: A start pulse with `rd_dir`=0, and any request outside an open read transaction, produce no `rd_valid` and no clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ac_mode | input | 1 | Load field presentation: 1 AC flag, 0 DC code |
| glob_evt | input | 8 | Global event inputs |
| ch_flt_evt | input | 6*NUM_CH | Per-channel fault events, 6 per channel |
| ch_load_vld | input | NUM_CH | Load result update strobe per channel |
| ch_load_res | input | 2*NUM_CH | Load detection result per channel |
| rd_start | input | 1 | Transaction start pulse; resets byte index |
| rd_dir | input | 1 | Direction with start: 1 read, 0 write |
| rd_req | input | 1 | Byte request strobe |
| rd_stop | input | 1 | Transaction stop pulse |
| rd_data | output | 8 | Returned status byte |
| rd_valid | output | 1 | `rd_data` holds a returned byte |

## Verification
The byte for a request is registered on the request edge, so `rd_valid` and `rd_data` are due one cycle after that edge. The clear, the forced bit 2 and event capture all take effect at the same edge and can only be seen through the next burst. The bench drives every input on the falling clock edge, holds it across one rising edge, and samples outputs at the following falling edge. Each check therefore lands on the single cycle where the registered result has just appeared. To verify sticky, exempt and same-cycle behaviour, the bench runs a further full burst and compares all five bytes.

// File: rtl/diag_pkg.sv
package diag_pkg;
    typedef logic [7:0] byte_t;

    // Fault events per channel (load field handled separately)
    localparam int CH_EVT_W = 6;
    // Width of stored load detection code
    localparam int LOAD_W   = 2;
    // Position of the offset bit inside the 6-bit fault vector
    localparam int FLT_OFS  = 2;
endpackage

// File: rtl/diag_glob.sv
module diag_glob
    import diag_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  byte_t rep_byte,
    input  byte_t evt,
    output byte_t view
);
    byte_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = st_q & ~rep_byte;
        end
        st_d = st_d | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign view = st_q;
endmodule

// File: rtl/diag_chan.sv
module diag_chan
    import diag_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ac_mode,
    input  logic                clr,
    input  byte_t               rep_byte,
    input  logic [CH_EVT_W-1:0] flt_evt,
    input  logic                load_vld,
    input  logic [LOAD_W-1:0]   load_res,
    output byte_t               view
);
    typedef struct packed {
        logic [CH_EVT_W-1:0] flt;
        logic [LOAD_W-1:0]   load;
    } chan_st_t;

    chan_st_t            st_d, st_q;
    logic [CH_EVT_W-1:0] rep_flt;
    logic [LOAD_W-1:0]   load_view;
    logic                unused_rep;

    // load field bits of the reported byte play no part in clearing
    assign unused_rep = ^rep_byte[5:4];

    always_comb begin
        rep_flt = {rep_byte[7:6], rep_byte[3:0]};
        st_d    = st_q;
        if (clr) begin
            st_d.flt          = st_q.flt & ~rep_flt;
            st_d.flt[FLT_OFS] = 1'b1;
        end
        st_d.flt = st_d.flt | flt_evt;
        if (load_vld) begin
            st_d.load = load_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (ac_mode) load_view = {1'b0, st_q.load[0]};
        else         load_view = st_q.load;
        view = {st_q.flt[5:4], load_view, st_q.flt[3:0]};
    end
endmodule

// File: rtl/diag_rdctl.sv
module diag_rdctl
    import diag_pkg::*;
#(
    parameter int NBYTES = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_start,
    input  logic                   rd_dir,
    input  logic                   rd_req,
    input  logic                   rd_stop,
    input  logic [NBYTES-1:0][7:0] live,
    output logic [NBYTES-1:0][7:0] snap,
    output logic                   clr,
    output byte_t                  rd_data,
    output logic                   rd_valid
);
    localparam int             IDXW     = $clog2(NBYTES + 1);
    localparam logic [IDXW-1:0] IDX_END  = IDXW'(NBYTES);
    localparam logic [IDXW-1:0] IDX_LAST = IDXW'(NBYTES - 1);

    typedef struct packed {
        logic                   active;
        logic [IDXW-1:0]        idx;
        logic [NBYTES-1:0][7:0] snap;
        logic                   valid;
        byte_t                  data;
    } rd_st_t;

    rd_st_t st_d, st_q;
    byte_t  sel;

    always_comb begin
        sel = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (st_q.idx == IDXW'(i)) sel = st_q.snap[i];
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.data  = '0;
        clr        = 1'b0;
        if (rd_start) begin
            st_d.active = rd_dir;
            st_d.idx    = '0;
            if (rd_dir) st_d.snap = live;
        end else if (rd_stop) begin
            st_d.active = 1'b0;
        end else if (rd_req && st_q.active) begin
            st_d.valid = 1'b1;
            if (st_q.idx < IDX_END) begin
                st_d.data = sel;
                st_d.idx  = st_q.idx + 1'b1;
            end
            if (st_q.idx == IDX_LAST) clr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign snap     = st_q.snap;
    assign rd_data  = st_q.data;
    assign rd_valid = st_q.valid;
endmodule

// File: rtl/diag_status_bank.sv
module diag_status_bank
    import diag_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ac_mode,
    input  logic [7:0]                   glob_evt,
    input  logic [NUM_CH*CH_EVT_W-1:0]   ch_flt_evt,
    input  logic [NUM_CH-1:0]            ch_load_vld,
    input  logic [NUM_CH*LOAD_W-1:0]     ch_load_res,
    input  logic                         rd_start,
    input  logic                         rd_dir,
    input  logic                         rd_req,
    input  logic                         rd_stop,
    output logic [7:0]                   rd_data,
    output logic                         rd_valid
);
    localparam int NBYTES = NUM_CH + 1;

    logic [NBYTES-1:0][7:0] live_bytes;
    logic [NBYTES-1:0][7:0] snap_bytes;
    logic                   burst_clr;

    diag_glob u_glob (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (burst_clr),
        .rep_byte (snap_bytes[0]),
        .evt      (glob_evt),
        .view     (live_bytes[0])
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        diag_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ac_mode  (ac_mode),
            .clr      (burst_clr),
            .rep_byte (snap_bytes[c+1]),
            .flt_evt  (ch_flt_evt[c*CH_EVT_W +: CH_EVT_W]),
            .load_vld (ch_load_vld[c]),
            .load_res (ch_load_res[c*LOAD_W +: LOAD_W]),
            .view     (live_bytes[c+1])
        );
    end

    diag_rdctl #(.NBYTES(NBYTES)) u_rdctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_start (rd_start),
        .rd_dir   (rd_dir),
        .rd_req   (rd_req),
        .rd_stop  (rd_stop),
        .live     (live_bytes),
        .snap     (snap_bytes),
        .clr      (burst_clr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/diag_status_bank_chk.sv
module diag_status_bank_chk #(
    parameter int NBYTES = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_start,
    input logic       rd_req,
    input logic       rd_valid,
    input logic [7:0] rd_data,
    input logic       clr,
    input logic [7:0] glob_evt,
    input logic [7:0] glob_view
);
    localparam int CW = $clog2(NBYTES + 2);

    logic [CW-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             seen_q <= '0;
        else if (rd_start)                      seen_q <= '0;
        else if (rd_valid && seen_q < CW'(NBYTES)) seen_q <= seen_q + 1'b1;
    end

    // R3
    valid_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));

    // R11
    no_data_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_valid);

    // R10
    extra_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && seen_q >= CW'(NBYTES)) |-> (rd_data == 8'h00));

    // R10
    single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !clr);

    // R5
    clear_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> rd_req);

    // R9
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_evt != 8'h00) |=> ((glob_view & $past(glob_evt)) == $past(glob_evt)));

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((glob_view & $past(glob_view)) == $past(glob_view)));
endmodule

bind diag_status_bank diag_status_bank_chk #(.NBYTES(NBYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_start  (rd_start),
    .rd_req    (rd_req),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .clr       (burst_clr),
    .glob_evt  (glob_evt),
    .glob_view (live_bytes[0])
);

// File: tb/tb_diag_status_bank.sv
module tb_diag_status_bank;
    localparam int NCH = 4;
    localparam int NB  = NCH + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ac_mode = 1'b0;
    logic [7:0]        glob_evt = '0;
    logic [NCH*6-1:0]  ch_flt_evt = '0;
    logic [NCH-1:0]    ch_load_vld = '0;
    logic [NCH*2-1:0]  ch_load_res = '0;
    logic              rd_start = 1'b0;
    logic              rd_dir = 1'b0;
    logic              rd_req = 1'b0;
    logic              rd_stop = 1'b0;
    logic [7:0]        rd_data;
    logic              rd_valid;

    int checks = 0;
    int errors = 0;

    diag_status_bank #(.NUM_CH(NCH)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ac_mode     (ac_mode),
        .glob_evt    (glob_evt),
        .ch_flt_evt  (ch_flt_evt),
        .ch_load_vld (ch_load_vld),
        .ch_load_res (ch_load_res),
        .rd_start    (rd_start),
        .rd_dir      (rd_dir),
        .rd_req      (rd_req),
        .rd_stop     (rd_stop),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid)
    );

    always #4 clk = ~clk;

    // {glob_evt[31:24], chan[23:22], flt_evt[21:16], exp_glob[15:8], exp_chan[7:0]}
    localparam logic [31:0] VEC [6] = '{
        {8'h81, 2'd0, 6'b100000, 8'h81, 8'h84},
        {8'h00, 2'd1, 6'b010001, 8'h00, 8'h45},
        {8'h3C, 2'd2, 6'b001010, 8'h3C, 8'h0E},
        {8'hFF, 2'd3, 6'b111111, 8'hFF, 8'hCF},
        {8'h02, 2'd0, 6'b000100, 8'h02, 8'h04},
        {8'h00, 2'd3, 6'b000000, 8'h00, 8'h04}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic start_txn(input logic dir);
        rd_start = 1'b1;
        rd_dir   = dir;
        @(negedge clk);
        rd_start = 1'b0;
        rd_dir   = 1'b0;
    endtask

    task automatic stop_txn();
        rd_stop = 1'b1;
        @(negedge clk);
        rd_stop = 1'b0;
    endtask

    task automatic pulse_evt(input logic [7:0] g, input logic [NCH*6-1:0] f);
        glob_evt   = g;
        ch_flt_evt = f;
        @(negedge clk);
        glob_evt   = '0;
        ch_flt_evt = '0;
    endtask

    task automatic read_byte(input logic [7:0] g, output logic [7:0] d, output logic v);
        rd_req   = 1'b1;
        glob_evt = g;
        @(negedge clk);
        rd_req   = 1'b0;
        glob_evt = '0;
        d = rd_data;
        v = rd_valid;
    endtask

    task automatic read_chk(input logic [7:0] exp, input string req);
        logic [7:0] d;
        logic       v;
        read_byte(8'h00, d, v);
        chk(req, {7'b0, v}, 8'h01);
        chk(req, d, exp);
    endtask

    task automatic burst(input logic [NB-1:0][7:0] exp, input string req);
        start_txn(1'b1);
        for (int i = 0; i < NB; i++) read_chk(exp[i], req);
        stop_txn();
    endtask

    function automatic logic [NB-1:0][7:0] base(input logic [7:0] g);
        logic [NB-1:0][7:0] e;
        for (int i = 1; i < NB; i++) e[i] = 8'h04;
        e[0] = g;
        return e;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [NB-1:0][7:0] e;
        logic [7:0]         d;
        logic               v;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {7'b0, rd_valid}, 8'h00);
        chk("R1 data in reset", rd_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", {7'b0, rd_valid}, 8'h00);
        e = '0;
        burst(e, "R1 first burst");

        // R2 R3 R5 R7: table of event patterns, each followed by a full burst
        for (int r = 0; r < 6; r++) begin
            logic [NCH*6-1:0] f;
            int               ch;
            ch = int'(VEC[r][23:22]);
            f  = '0;
            f[ch*6 +: 6] = VEC[r][21:16];
            pulse_evt(VEC[r][31:24], f);
            e = base(VEC[r][15:8]);
            e[ch+1] = VEC[r][7:0];
            burst(e, "R2/R3/R5/R7 table");
        end

        // R4: event after start is not in this burst, R9: it survives the clear
        start_txn(1'b1);
        pulse_evt(8'h10, '0);
        e = base(8'h00);
        for (int i = 0; i < NB; i++) read_chk(e[i], "R4 snapshot");
        stop_txn();
        burst(base(8'h10), "R9 unreported kept");
        burst(base(8'h00), "R5 cleared after report");

        // R9: event in the same cycle as the clear
        pulse_evt(8'h08, '0);
        start_txn(1'b1);
        read_chk(8'h08, "R9 byte0");
        for (int i = 1; i < NB - 1; i++) read_chk(8'h04, "R9 chan");
        read_byte(8'h08, d, v);
        chk("R9 last valid", {7'b0, v}, 8'h01);
        chk("R9 last data", d, 8'h04);
        stop_txn();
        burst(base(8'h08), "R9 event wins");
        burst(base(8'h00), "R9 then cleared");

        // R5: partial burst clears nothing
        pulse_evt(8'h00, 24'h000800);
        start_txn(1'b1);
        read_chk(8'h00, "R5 partial");
        read_chk(8'h04, "R5 partial");
        read_chk(8'h84, "R5 partial");
        stop_txn();
        e = base(8'h00);
        e[2] = 8'h84;
        burst(e, "R5 kept after partial");
        burst(base(8'h00), "R5 cleared after full");

        // R10: extra reads return zero and clear nothing
        pulse_evt(8'h40, '0);
        start_txn(1'b1);
        e = base(8'h40);
        for (int i = 0; i < NB; i++) read_chk(e[i], "R10 burst");
        pulse_evt(8'h40, '0);
        read_chk(8'h00, "R10 extra");
        read_chk(8'h00, "R10 extra");
        stop_txn();
        burst(base(8'h40), "R10 no second clear");
        burst(base(8'h00), "R10 tidy");

        // R11: write direction and requests outside a transaction
        pulse_evt(8'h01, '0);
        start_txn(1'b0);
        for (int i = 0; i < NB; i++) begin
            read_byte(8'h00, d, v);
            chk("R11 write dir no valid", {7'b0, v}, 8'h00);
        end
        stop_txn();
        read_byte(8'h00, d, v);
        chk("R11 after stop no valid", {7'b0, v}, 8'h00);
        burst(base(8'h01), "R11 no clear");
        burst(base(8'h00), "R11 tidy");

        // R6 R8: load field presentation and exemption
        ch_load_vld = 4'b0100;
        ch_load_res = 8'b00_10_00_00;
        @(negedge clk);
        ch_load_vld = '0;
        ch_load_res = '0;
        e = base(8'h00);
        e[3] = 8'h24;
        burst(e, "R8 DC open load");
        burst(e, "R6 load kept after clear");
        ac_mode = 1'b1;
        e[3] = 8'h04;
        burst(e, "R8 AC no load");
        ch_load_vld = 4'b0100;
        ch_load_res = 8'b00_11_00_00;
        @(negedge clk);
        ch_load_vld = '0;
        ch_load_res = '0;
        e[3] = 8'h14;
        burst(e, "R8 AC load present");
        ac_mode = 1'b0;
        e[3] = 8'h34;
        burst(e, "R8 DC invalid code");
        burst(e, "R6 exempt again");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule